// File: doc/BRIEF.md
# Register Alias Table with Physical Tags

This block renames the register operands of micro-ops. It holds one mapping entry for each of 16 architectural registers. Each entry either names one of 40 physical tags, or marks the register as architectural. Architectural means the committed register file holds the current value. Each cycle, at most one micro-op arrives. The block looks up the current mapping of both source registers. If the micro-op writes a register, the block binds the destination to the free tag offered on `alloc_tag` and pulses `alloc_take` so the external free list advances. The renamed micro-op leaves one cycle later, in the order it arrived.

Giving every write a new tag removes write-after-read and write-after-write conflicts. Readers that arrive after a write see the newest tag. A micro-op that reads and writes the same register still sees the older mapping for its source. When a tag retires, any entry that still points at it returns to the architectural state. A flush returns every entry to that state at once.

Top module: `rat_rename`

## Requirements
- R1: After reset every entry is architectural, `out_valid` is low and `alloc_take` is low.
- R2: A source whose entry holds a tag is reported one cycle later with its `_ren` flag set to 1 and that 6-bit tag, where tags run 0 to 39. A source whose entry is architectural is reported with `_ren` at 0 and tag 0.
- R3: A micro-op with a destination binds that register to `alloc_tag`, and later micro-ops that read the register receive that tag. If the same micro-op also reads that register, its source receives the mapping from before the write.
- R4: Two writes to one register in consecutive micro-ops leave the second tag in place. A micro-op between them reads the first tag.
- R5: A micro-op without a destination leaves `alloc_take` low, reports `out_dst_en` as 0 and leaves every entry unchanged.
- R6: A retiring tag that equals an entry's current tag returns that entry to the architectural state. A retiring tag that matches no current tag changes nothing.
- R7: When a register is renamed in the same cycle that its current tag retires, the entry takes the new tag.
- R8: A source looked up in the same cycle that its current tag retires is reported as architectural.
- R9: A flush makes every entry architectural in one cycle. A micro-op presented together with a flush produces no output, takes no tag and changes no entry.
- R10: `alloc_take` is high, in the same cycle, exactly when a valid micro-op with a destination is presented without a flush.
- R11: Each accepted micro-op produces exactly one `out_valid` pulse, one cycle after it is presented, in program order. No pulse appears without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A micro-op is presented this cycle |
| in_src0 | input | 4 | First source architectural register |
| in_src1 | input | 4 | Second source architectural register |
| in_has_dst | input | 1 | Micro-op writes a register |
| in_dst | input | 4 | Destination architectural register |
| alloc_tag | input | 6 | Free physical tag offered by the free list |
| alloc_take | output | 1 | Offered tag is consumed this cycle |
| ret_valid | input | 1 | A tag retires this cycle |
| ret_tag | input | 6 | Retiring physical tag |
| flush | input | 1 | Return all mappings to the architectural state |
| out_valid | output | 1 | Renamed micro-op valid |
| out_src0_ren | output | 1 | First source maps to a physical tag |
| out_src0_tag | output | 6 | First source tag |
| out_src1_ren | output | 1 | Second source maps to a physical tag |
| out_src1_tag | output | 6 | Second source tag |
| out_dst_en | output | 1 | Renamed micro-op has a destination |
| out_dst_areg | output | 4 | Destination architectural register |
| out_dst_tag | output | 6 | Destination physical tag |

## Verification
The delicate cycles are those where a retirement meets a rename or a lookup on the same register. The bench provokes both cases with directed stimulus. In one cycle it retires a register's live tag while renaming that register, so the new tag must survive. In another it retires the live tag while a source reads that register, so the source must come back architectural. A randomized phase then overlaps retirements, renames and occasional flushes. Every returned micro-op is compared with a bench-side mapping model that applies flush, then rename, then retire-clear priority.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int unsigned RAT_ARCH_REGS = 16;
  localparam int unsigned RAT_PHYS_TAGS = 40;

  // Action applied to one mapping entry at the clock edge
  typedef enum logic [1:0] {
    ENT_HOLD  = 2'd0,
    ENT_LOAD  = 2'd1,
    ENT_CLEAR = 2'd2
  } ent_act_e;
endpackage

// File: rtl/rat_rst_sync.sv
module rat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/rat_map_entry.sv
module rat_map_entry
  import rat_pkg::*;
#(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  output logic             ent_vld,
  output logic [TAG_W-1:0] ent_tag
);
  ent_act_e act;
  logic     ret_hit;
  logic     vld_d;
  logic     tag_en;

  // Priority: flush, then new rename, then retire clear
  always_comb begin
    ret_hit = ret_valid && ent_vld && (ent_tag == ret_tag);
    if (flush)        act = ENT_CLEAR;
    else if (wr_en)   act = ENT_LOAD;
    else if (ret_hit) act = ENT_CLEAR;
    else              act = ENT_HOLD;
  end

  always_comb begin
    case (act)
      ENT_LOAD:  vld_d = 1'b1;
      ENT_CLEAR: vld_d = 1'b0;
      default:   vld_d = ent_vld;
    endcase
    tag_en = (act == ENT_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_vld <= 1'b0;
    else        ent_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_tag <= '0;
    else if (tag_en) ent_tag <= wr_tag;
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ent_vld); // R9

  AST_RENAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (ent_vld && ent_tag == $past(wr_tag))); // R7

  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ent_vld && ent_tag == ret_tag && !wr_en && !flush) |=> !ent_vld); // R6
endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup #(
  parameter int unsigned N_ARCH = 16,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned AREG_W = 4
) (
  input  logic [N_ARCH-1:0]            tbl_vld,
  input  logic [N_ARCH-1:0][TAG_W-1:0] tbl_tag,
  input  logic [AREG_W-1:0]            areg,
  input  logic                         ret_valid,
  input  logic [TAG_W-1:0]             ret_tag,
  output logic                         ren,
  output logic [TAG_W-1:0]             tag
);
  logic             sel_vld;
  logic [TAG_W-1:0] sel_tag;
  logic             retiring;

  always_comb begin
    sel_vld  = tbl_vld[areg];
    sel_tag  = tbl_tag[areg];
    // A tag leaving this cycle is already committed: read the architectural copy
    retiring = ret_valid && (sel_tag == ret_tag);
    ren      = sel_vld && !retiring;
    tag      = ren ? sel_tag : '0;
  end
endmodule

// File: rtl/rat_out_stage.sv
module rat_out_stage #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned AREG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              s0_ren,
  input  logic [TAG_W-1:0]  s0_tag,
  input  logic              s1_ren,
  input  logic [TAG_W-1:0]  s1_tag,
  input  logic              dst_en,
  input  logic [AREG_W-1:0] dst_areg,
  input  logic [TAG_W-1:0]  dst_tag,
  output logic              out_valid,
  output logic              out_s0_ren,
  output logic [TAG_W-1:0]  out_s0_tag,
  output logic              out_s1_ren,
  output logic [TAG_W-1:0]  out_s1_tag,
  output logic              out_dst_en,
  output logic [AREG_W-1:0] out_dst_areg,
  output logic [TAG_W-1:0]  out_dst_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_s0_ren   <= 1'b0;
      out_s0_tag   <= '0;
      out_s1_ren   <= 1'b0;
      out_s1_tag   <= '0;
      out_dst_en   <= 1'b0;
      out_dst_areg <= '0;
      out_dst_tag  <= '0;
    end else if (load) begin
      out_s0_ren   <= s0_ren;
      out_s0_tag   <= s0_tag;
      out_s1_ren   <= s1_ren;
      out_s1_tag   <= s1_tag;
      out_dst_en   <= dst_en;
      out_dst_areg <= dst_areg;
      out_dst_tag  <= dst_en ? dst_tag : '0;
    end
  end

  AST_OUT_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid); // R11
endmodule

// File: rtl/rat_rename.sv
module rat_rename
  import rat_pkg::*;
#(
  parameter  int unsigned N_ARCH = RAT_ARCH_REGS,
  parameter  int unsigned N_PHYS = RAT_PHYS_TAGS,
  localparam int unsigned AREG_W = $clog2(N_ARCH),
  localparam int unsigned TAG_W  = $clog2(N_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [AREG_W-1:0] in_src0,
  input  logic [AREG_W-1:0] in_src1,
  input  logic              in_has_dst,
  input  logic [AREG_W-1:0] in_dst,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              alloc_take,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              flush,
  output logic              out_valid,
  output logic              out_src0_ren,
  output logic [TAG_W-1:0]  out_src0_tag,
  output logic              out_src1_ren,
  output logic [TAG_W-1:0]  out_src1_tag,
  output logic              out_dst_en,
  output logic [AREG_W-1:0] out_dst_areg,
  output logic [TAG_W-1:0]  out_dst_tag
);
  localparam int unsigned N_SRC = 2;

  logic                         rst_n_s;
  logic                         take;
  logic                         accept;
  logic [N_ARCH-1:0]            wr_en;
  logic [N_ARCH-1:0]            tbl_vld;
  logic [N_ARCH-1:0][TAG_W-1:0] tbl_tag;
  logic [N_SRC-1:0][AREG_W-1:0] src_areg;
  logic [N_SRC-1:0]             src_ren;
  logic [N_SRC-1:0][TAG_W-1:0]  src_tag;

  rat_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    accept      = in_valid && !flush;
    take        = accept && in_has_dst;
    alloc_take  = take;
    src_areg[0] = in_src0;
    src_areg[1] = in_src1;
  end

  // Destination decode and one mapping entry per architectural register
  for (genvar r = 0; r < N_ARCH; r++) begin : g_entry
    assign wr_en[r] = take && (in_dst == AREG_W'(r));

    rat_map_entry #(.TAG_W(TAG_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .flush     (flush),
      .wr_en     (wr_en[r]),
      .wr_tag    (alloc_tag),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .ent_vld   (tbl_vld[r]),
      .ent_tag   (tbl_tag[r])
    );
  end

  // Source lookups see the table before this cycle's rename
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    rat_src_lookup #(
      .N_ARCH (N_ARCH),
      .TAG_W  (TAG_W),
      .AREG_W (AREG_W)
    ) u_lookup (
      .tbl_vld   (tbl_vld),
      .tbl_tag   (tbl_tag),
      .areg      (src_areg[s]),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .ren       (src_ren[s]),
      .tag       (src_tag[s])
    );
  end

  rat_out_stage #(
    .TAG_W  (TAG_W),
    .AREG_W (AREG_W)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .load         (accept),
    .s0_ren       (src_ren[0]),
    .s0_tag       (src_tag[0]),
    .s1_ren       (src_ren[1]),
    .s1_tag       (src_tag[1]),
    .dst_en       (in_has_dst),
    .dst_areg     (in_dst),
    .dst_tag      (alloc_tag),
    .out_valid    (out_valid),
    .out_s0_ren   (out_src0_ren),
    .out_s0_tag   (out_src0_tag),
    .out_s1_ren   (out_src1_ren),
    .out_s1_tag   (out_src1_tag),
    .out_dst_en   (out_dst_en),
    .out_dst_areg (out_dst_areg),
    .out_dst_tag  (out_dst_tag)
  );

  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    alloc_take |-> (alloc_tag < TAG_W'(N_PHYS))); // R3

  AST_NO_OUT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> !out_valid); // R9
endmodule

// File: tb/rat_rename_tb.sv
module rat_rename_tb;
  localparam int unsigned NA = 16;
  localparam int unsigned TW = 6;
  localparam int unsigned AW = 4;
  localparam int unsigned NP = 40;
  localparam int unsigned IW = 25;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_src0;
  logic [AW-1:0] in_src1;
  logic          in_has_dst;
  logic [AW-1:0] in_dst;
  logic [TW-1:0] alloc_tag;
  logic          alloc_take;
  logic          ret_valid;
  logic [TW-1:0] ret_tag;
  logic          flush;
  logic          out_valid;
  logic          out_src0_ren;
  logic [TW-1:0] out_src0_tag;
  logic          out_src1_ren;
  logic [TW-1:0] out_src1_tag;
  logic          out_dst_en;
  logic [AW-1:0] out_dst_areg;
  logic [TW-1:0] out_dst_tag;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  logic [IW-1:0] exp_q [$];
  int            req_q [$];

  bit            m_vld [NA];
  logic [TW-1:0] m_tag [NA];

  rat_rename u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src0(in_src0),
    .in_src1(in_src1), .in_has_dst(in_has_dst), .in_dst(in_dst),
    .alloc_tag(alloc_tag), .alloc_take(alloc_take), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .flush(flush), .out_valid(out_valid),
    .out_src0_ren(out_src0_ren), .out_src0_tag(out_src0_tag),
    .out_src1_ren(out_src1_ren), .out_src1_tag(out_src1_tag),
    .out_dst_en(out_dst_en), .out_dst_areg(out_dst_areg),
    .out_dst_tag(out_dst_tag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: presents one cycle of stimulus and pushes the expected result
  task automatic drive(input bit v, input int s0, input int s1, input bit hd,
                       input int d, input int at, input bit rv, input int rt,
                       input bit fl, input int req);
    bit            r0, r1;
    logic [TW-1:0] t0, t1;
    @(negedge clk);
    in_valid = v; in_src0 = AW'(s0); in_src1 = AW'(s1); in_has_dst = hd;
    in_dst = AW'(d); alloc_tag = TW'(at); ret_valid = rv; ret_tag = TW'(rt);
    flush = fl;
    r0 = m_vld[s0] && !(rv && m_tag[s0] == TW'(rt));
    r1 = m_vld[s1] && !(rv && m_tag[s1] == TW'(rt));
    t0 = r0 ? m_tag[s0] : '0;
    t1 = r1 ? m_tag[s1] : '0;
    if (v && !fl) begin
      exp_q.push_back({r0, t0, r1, t1, hd, AW'(d), hd ? TW'(at) : TW'(0)});
      req_q.push_back(req);
    end
    #1;
    // R10: same-cycle tag consumption
    check(alloc_take == (v && hd && !fl), 10, 32'(alloc_take), 32'(v && hd && !fl));
    if (fl) begin
      for (int r = 0; r < NA; r++) m_vld[r] = 1'b0;
    end else begin
      for (int r = 0; r < NA; r++) begin
        if (v && hd && d == r) begin
          m_vld[r] = 1'b1; m_tag[r] = TW'(at);
        end else if (rv && m_vld[r] && m_tag[r] == TW'(rt)) begin
          m_vld[r] = 1'b0;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
  endtask

  // Monitor: compare each renamed micro-op with the scoreboard head
  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 11, 32'(out_valid), 32'd0);
      end else begin
        logic [IW-1:0] e;
        logic [IW-1:0] a;
        int            rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        a  = {out_src0_ren, out_src0_tag, out_src1_ren, out_src1_tag,
              out_dst_en, out_dst_areg, out_dst_tag};
        check(a == e, rq, 32'(a), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    int seed;
    int nt;
    for (int r = 0; r < NA; r++) begin m_vld[r] = 1'b0; m_tag[r] = '0; end
    rst_n = 1'b0; in_valid = 0; in_src0 = 0; in_src1 = 0; in_has_dst = 0;
    in_dst = 0; alloc_tag = 0; ret_valid = 0; ret_tag = 0; flush = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, 1, 32'(out_valid), 32'd0);
    check(alloc_take == 1'b0, 1, 32'(alloc_take), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(1, 1, 2, 0, 0, 0, 0, 0, 0, 1);    // R1: all sources architectural
    drive(1, 3, 4, 1, 3, 5, 0, 0, 0, 3);    // R3: self read sees old mapping
    drive(1, 3, 4, 1, 3, 7, 0, 0, 0, 4);    // R4: reads tag 5, writes tag 7
    drive(1, 3, 3, 0, 0, 0, 0, 0, 0, 4);    // R4: newest tag 7 (R2 ren=1)
    drive(1, 3, 6, 0, 0, 0, 1, 5, 0, 6);    // R6: stale tag retire, no effect
    drive(1, 3, 3, 0, 0, 0, 0, 0, 0, 6);    // R6: still tag 7
    drive(1, 3, 3, 0, 0, 0, 1, 7, 0, 8);    // R8: retiring tag looked up
    drive(1, 3, 0, 0, 0, 0, 0, 0, 0, 6);    // R6: entry back to architectural
    drive(1, 5, 0, 1, 5, 9, 0, 0, 0, 3);
    drive(1, 0, 0, 1, 5, 12, 1, 9, 0, 7);   // R7: rename beats retire clear
    drive(1, 5, 5, 0, 0, 0, 0, 0, 0, 7);    // R7: tag 12 kept
    drive(1, 0, 15, 0, 0, 0, 0, 0, 0, 5);   // R5: no-dst op changed nothing
    drive(1, 0, 0, 1, 0, 39, 0, 0, 0, 2);   // R2: highest tag
    drive(1, 0, 0, 1, 15, 38, 0, 0, 0, 2);
    drive(1, 0, 15, 0, 0, 0, 0, 0, 0, 2);
    drive(1, 2, 2, 1, 2, 20, 0, 0, 1, 9);   // R9: dropped with flush
    idle(2);                                 // R11: no spurious output
    drive(1, 0, 15, 0, 0, 0, 0, 0, 0, 9);   // R9: all architectural
    drive(1, 5, 2, 0, 0, 0, 0, 0, 0, 9);

    // Mixed traffic with overlapping retire, rename and flush
    seed = 32'h1234_5678;
    nt = 0;
    for (int i = 0; i < 400; i++) begin
      bit v, hd, rv, fl;
      seed = seed * 1103515245 + 12345;
      v  = seed[20] | seed[21];
      hd = seed[22];
      rv = seed[23];
      fl = (seed[29:25] == 5'd0);
      drive(v, int'(seed[3:0]), int'(seed[7:4]), hd, int'(seed[11:8]),
            nt, rv, int'(seed[17:12]) % NP, fl, 11);
      if (v && hd && !fl) nt = (nt + 1) % NP;
    end
    idle(3);
    check(exp_q.size() == 0, 11, 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule